// File: doc/BRIEF.md
# Scan-Accessed Trace Capture Buffer

This block stores a stream of 32-bit trace words in a circular RAM and gives a debugger access to it through one serial scan register. The TAP controller is not part of the block: it delivers single-cycle capture, shift and update strobes plus a serial input bit, and takes the serial output bit back. Each scan moves a 40-bit frame. The frame holds a 32-bit data field, a 7-bit register address and a write flag.

An update with the write flag set stores the data field into the addressed register. An update with the flag clear only requests a read. The requested value is loaded into the data field by the next capture, so every read takes two scans. The RAM data port has a side effect: each read request on it returns the entry under the read pointer and moves the pointer forward. A follow-up scan that only collects a result should therefore request the identification register, so that it does not consume a RAM entry.

The register bank has nine addresses. Capture is switched on and off through the control register. A sticky status flag records that the write pointer has wrapped. Once it is set, the oldest stored word sits at the write pointer; before that, the oldest word is at entry 0.

Top module: `tbuf_scan_regs`

## Requirements
- R1: A frame is 40 bits and is shifted least significant bit first. Bits 31:0 are the data field, bits 38:32 the register address, and bit 39 the write flag. Each shift strobe moves the register one place and presents its bit 0 on `scan_tdo`.
- R2: An update with the write flag at 1 writes the data field into the addressed writable register (addresses 5, 7 and 8).
- R3: An update with the write flag at 0 latches the addressed register's value. The next capture loads that value into bits 31:0 and zero into bits 39:32.
- R4: Address 0 reads the identification constant `ID_VALUE`. Address 1 reads `DEPTH`. Address 2 reads 32.
- R5: A read request to address 4 returns the RAM entry at the read pointer and then advances the pointer by one, modulo `DEPTH`. A read request to any other address leaves the pointer unchanged.
- R6: Address 3 (status) reads bit 0 = capture enabled and bit 1 = write pointer has wrapped, with all other bits zero. The wrap bit sets when a word is stored at entry `DEPTH-1` and stays set until reset.
- R7: The read pointer at address 5 is readable. A write stores the data field modulo `DEPTH`.
- R8: Control (address 8) bit 0 enables capture, and the control register reads back only that bit. On every clock cycle while capture is enabled, `trace_word` is stored at the write pointer and the pointer advances modulo `DEPTH`. The write pointer reads at address 6.
- R9: Address 7 (trigger count) stores and returns a full 32-bit value.
- R10: Addresses 9 to 127 read as zero. Writes to them, and writes to addresses 0, 1, 2, 3, 4 and 6, change no register.
- R11: After reset, the pointers, the control bit, the wrap flag, the trigger count and the pending read value are all zero. `scan_tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_capture | input | 1 | Capture strobe: loads pending read data into the frame |
| scan_shift | input | 1 | Shift strobe: moves the frame one bit |
| scan_update | input | 1 | Update strobe: performs the frame's access |
| scan_tdi | input | 1 | Serial frame input |
| scan_tdo | output | 1 | Serial frame output |
| trace_word | input | 32 | Trace word stored each enabled cycle |

## Verification
The assertions assume that the TAP side raises at most one of the capture, shift and update strobes in any cycle. The frame logic relies on this, and one assertion guards it. The bench keeps within this assumption by driving each strobe from a single sequential task, one strobe per clock. Each scan is exactly one capture, forty shifts and one update. RAM contents are read back only after a full wrap, so every entry read has been written.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned FRAME_W = DATA_W + ADDR_W + 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_IDENT = 7'd0,
    REG_DEPTH = 7'd1,
    REG_WIDTH = 7'd2,
    REG_STAT  = 7'd3,
    REG_RDATA = 7'd4,
    REG_RPTR  = 7'd5,
    REG_WPTR  = 7'd6,
    REG_TRIG  = 7'd7,
    REG_CTRL  = 7'd8
  } tbuf_reg_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } tbuf_frame_t;

  // Next pointer value in a ring of the given depth.
  function automatic logic [31:0] ptr_next(logic [31:0] p, int unsigned depth);
    return (p == depth - 1) ? 32'd0 : p + 32'd1;
  endfunction

  // Fold an arbitrary written value into the ring.
  function automatic logic [31:0] ptr_fold(logic [31:0] v, int unsigned depth);
    return v % depth;
  endfunction
endpackage

// File: rtl/tbuf_scan_shift.sv
module tbuf_scan_shift
  import tbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output tbuf_frame_t       frame,
  output logic              tdo
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)       sr <= '0;
    else if (capture) sr <= {{(FRAME_W-DATA_W){1'b0}}, cap_data};
    else if (shift)   sr <= {tdi, sr[FRAME_W-1:1]};
  end

  assign frame = tbuf_frame_t'(sr);
  assign tdo   = sr[0];
endmodule

// File: rtl/tbuf_trace_ram.sv
module tbuf_trace_ram
  import tbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] trace_word,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     wr_ptr,
  output logic              wrapped
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cap_en) mem[wr_ptr] <= trace_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else if (cap_en) begin
      wr_ptr <= AW'(ptr_next(32'(wr_ptr), DEPTH));
      if (32'(wr_ptr) == DEPTH - 1) wrapped <= 1'b1;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tbuf_reg_bank.sv
module tbuf_reg_bank
  import tbuf_pkg::*;
#(
  parameter int unsigned DEPTH    = 256,
  parameter logic [31:0] ID_VALUE = 32'h4B71_0E05,
  localparam int unsigned AW      = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  tbuf_frame_t       frame,
  input  logic [DATA_W-1:0] ram_rd_data,
  input  logic [AW-1:0]     wr_ptr,
  input  logic              wrapped,
  output logic [AW-1:0]     rd_ptr,
  output logic              cap_en,
  output logic [DATA_W-1:0] rd_hold,
  output logic              data_rd_evt,
  output logic              rp_wr_evt
);
  logic [DATA_W-1:0] trig_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (frame.addr)
      REG_IDENT: rd_mux = ID_VALUE;
      REG_DEPTH: rd_mux = DATA_W'(DEPTH);
      REG_WIDTH: rd_mux = DATA_W'(DATA_W);
      REG_STAT:  rd_mux = {30'd0, wrapped, cap_en};
      REG_RDATA: rd_mux = ram_rd_data;
      REG_RPTR:  rd_mux = DATA_W'(rd_ptr);
      REG_WPTR:  rd_mux = DATA_W'(wr_ptr);
      REG_TRIG:  rd_mux = trig_q;
      REG_CTRL:  rd_mux = {31'd0, cap_en};
      default:   rd_mux = '0;
    endcase
  end

  assign data_rd_evt = upd && !frame.wr && (frame.addr == REG_RDATA);
  assign rp_wr_evt   = upd &&  frame.wr && (frame.addr == REG_RPTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      cap_en  <= 1'b0;
      trig_q  <= '0;
      rd_hold <= '0;
    end else if (upd) begin
      if (frame.wr) begin
        case (frame.addr)
          REG_RPTR: rd_ptr <= AW'(ptr_fold(frame.data, DEPTH));
          REG_TRIG: trig_q <= frame.data;
          REG_CTRL: cap_en <= frame.data[0];
          default: ;
        endcase
      end else begin
        rd_hold <= rd_mux;
        if (data_rd_evt) rd_ptr <= AW'(ptr_next(32'(rd_ptr), DEPTH));
      end
    end
  end
endmodule

// File: rtl/tbuf_scan_regs.sv
module tbuf_scan_regs
  import tbuf_pkg::*;
#(
  parameter int unsigned DEPTH    = 256,
  parameter logic [31:0] ID_VALUE = 32'h4B71_0E05
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_capture,
  input  logic        scan_shift,
  input  logic        scan_update,
  input  logic        scan_tdi,
  output logic        scan_tdo,
  input  logic [31:0] trace_word
);
  localparam int unsigned AW = $clog2(DEPTH);

  tbuf_frame_t       frame;
  logic [DATA_W-1:0] rd_hold;
  logic [DATA_W-1:0] ram_rd_data;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic              wrapped;
  logic              cap_en;
  logic              data_rd_evt;
  logic              rp_wr_evt;

  tbuf_scan_shift u_shift (
    .clk(clk), .rst_n(rst_n), .capture(scan_capture), .shift(scan_shift),
    .tdi(scan_tdi), .cap_data(rd_hold), .frame(frame), .tdo(scan_tdo)
  );

  tbuf_trace_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .trace_word(trace_word),
    .rd_addr(rd_ptr), .rd_data(ram_rd_data), .wr_ptr(wr_ptr), .wrapped(wrapped)
  );

  tbuf_reg_bank #(.DEPTH(DEPTH), .ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rst_n(rst_n), .upd(scan_update), .frame(frame),
    .ram_rd_data(ram_rd_data), .wr_ptr(wr_ptr), .wrapped(wrapped),
    .rd_ptr(rd_ptr), .cap_en(cap_en), .rd_hold(rd_hold),
    .data_rd_evt(data_rd_evt), .rp_wr_evt(rp_wr_evt)
  );
endmodule

// File: rtl/tbuf_scan_regs_chk.sv
module tbuf_scan_regs_chk
  import tbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          scan_capture,
  input logic          scan_shift,
  input logic          scan_update,
  input logic          cap_en,
  input logic [AW-1:0] wr_ptr,
  input logic          wrapped,
  input logic [AW-1:0] rd_ptr,
  input logic          data_rd_evt,
  input logic          rp_wr_evt
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_capture, scan_shift, scan_update})); // R1

  AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> wr_ptr == AW'(ptr_next(32'($past(wr_ptr)), DEPTH))); // R8

  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(wr_ptr)); // R8

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped); // R6

  AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && 32'(wr_ptr) == DEPTH - 1) |=> wrapped); // R6

  AST_RP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_evt |=> rd_ptr == AW'(ptr_next(32'($past(rd_ptr)), DEPTH))); // R5

  AST_RP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_rd_evt && !rp_wr_evt) |=> $stable(rd_ptr)); // R5

  AST_RP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_ptr) < DEPTH); // R7
endmodule

bind tbuf_scan_regs tbuf_scan_regs_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_capture(scan_capture), .scan_shift(scan_shift),
  .scan_update(scan_update), .cap_en(cap_en), .wr_ptr(wr_ptr), .wrapped(wrapped),
  .rd_ptr(rd_ptr), .data_rd_evt(data_rd_evt), .rp_wr_evt(rp_wr_evt)
);

// File: tb/tbuf_scan_regs_bench.sv
module tbuf_scan_regs_bench;
  localparam int unsigned D     = 256;
  localparam logic [31:0] ID    = 32'h4B71_0E05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_capture = 1'b0, scan_shift = 1'b0, scan_update = 1'b0, scan_tdi = 1'b0;
  logic scan_tdo;
  logic [31:0] trace_word = 32'h1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tbuf_scan_regs #(.DEPTH(D), .ID_VALUE(ID)) u_tbuf_scan_regs (
    .clk(clk), .rst_n(rst_n), .scan_capture(scan_capture), .scan_shift(scan_shift),
    .scan_update(scan_update), .scan_tdi(scan_tdi), .scan_tdo(scan_tdo),
    .trace_word(trace_word)
  );

  always @(negedge clk) trace_word <= trace_word + 32'h9E37_79B9;

  // Behavioural reference model
  logic [31:0] m_mem [D];
  int unsigned m_wp, m_rp;
  bit          m_wrap, m_en;
  logic [31:0] m_trig, m_hold;
  logic [39:0] m_exp;
  logic [31:0] f_data;
  int unsigned f_addr;
  bit          f_wr;

  function automatic logic [31:0] m_read(int unsigned a);
    case (a)
      0: return ID;
      1: return 32'(D);
      2: return 32'd32;
      3: return {30'd0, m_wrap, m_en};
      4: return m_mem[m_rp];
      5: return 32'(m_rp);
      6: return 32'(m_wp);
      7: return m_trig;
      8: return {31'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wp = 0; m_rp = 0; m_wrap = 0; m_en = 0; m_trig = 0; m_hold = 0; m_exp = 0;
    end else begin
      bit old_en;
      old_en = m_en;
      if (scan_capture) m_exp = {8'd0, m_hold};
      if (scan_update) begin
        if (f_wr) begin
          if (f_addr == 5) m_rp = f_data % D;
          if (f_addr == 7) m_trig = f_data;
          if (f_addr == 8) m_en = f_data[0];
        end else begin
          m_hold = m_read(f_addr);
          if (f_addr == 4) m_rp = (m_rp + 1) % D;
        end
      end
      if (old_en) begin
        m_mem[m_wp] = trace_word;
        if (m_wp == D - 1) m_wrap = 1;
        m_wp = (m_wp + 1) % D;
      end
    end
  end

  task automatic chk(string tag, logic [39:0] got, logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One full scan; the returned frame is compared with the model every time.
  task automatic scan(input logic [31:0] d, input logic [6:0] a, input logic wr,
                      output logic [39:0] got);
    logic [39:0] fr;
    fr = {wr, a, d};
    @(negedge clk) scan_capture = 1'b1;
    @(negedge clk) scan_capture = 1'b0;
    for (int k = 0; k < 40; k++) begin
      got[k] = scan_tdo;
      scan_shift = 1'b1;
      scan_tdi = fr[k];
      @(negedge clk);
    end
    scan_shift = 1'b0;
    chk("R1 R3 captured frame vs model", got, m_exp);
    f_data = d; f_addr = 32'(a); f_wr = wr;
    scan_update = 1'b1;
    @(negedge clk) scan_update = 1'b0;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
    logic [39:0] g;
    scan(d, a, 1'b1, g);
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [31:0] v);
    logic [39:0] g;
    scan(32'd0, a, 1'b0, g);
    scan(32'd0, 7'd0, 1'b0, g);
    v = g[31:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, wp0;
    logic [39:0] g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 tdo after reset", {39'd0, scan_tdo}, 40'd0);
    rd_reg(7'd3, v); chk("R11 R6 status after reset", {8'd0, v}, 40'd0);
    rd_reg(7'd0, v); chk("R4 identification", {8'd0, v}, {8'd0, ID});
    rd_reg(7'd1, v); chk("R4 depth", {8'd0, v}, 40'd256);
    rd_reg(7'd2, v); chk("R4 width", {8'd0, v}, 40'd32);
    rd_reg(7'd7, v); chk("R11 trigger count after reset", {8'd0, v}, 40'd0);

    wr_reg(7'd7, 32'hDEAD_BEEF);
    rd_reg(7'd7, v); chk("R9 R2 trigger count store", {8'd0, v}, 40'h00DEAD_BEEF);

    wr_reg(7'd9, 32'h1234_5678);
    rd_reg(7'd9, v); chk("R10 address 9 reads zero", {8'd0, v}, 40'd0);
    wr_reg(7'd127, 32'hFFFF_FFFF);
    rd_reg(7'd127, v); chk("R10 address 127 reads zero", {8'd0, v}, 40'd0);
    wr_reg(7'd0, 32'h0);
    rd_reg(7'd0, v); chk("R10 identification write ignored", {8'd0, v}, {8'd0, ID});
    rd_reg(7'd7, v); chk("R10 trigger untouched by stray writes", {8'd0, v}, 40'h00DEAD_BEEF);

    // Short capture run, no wrap yet
    wr_reg(7'd8, 32'hFFFF_FFFF);
    rd_reg(7'd8, v); chk("R8 control reads only bit 0", {8'd0, v}, 40'd1);
    rd_reg(7'd3, v); chk("R6 status enabled, no wrap", {8'd0, v}, 40'd1);
    wr_reg(7'd8, 32'h0);
    rd_reg(7'd6, v); chk("R8 write pointer vs model", {8'd0, v}, {8'd0, 32'(m_wp)});
    wp0 = v;
    wr_reg(7'd6, 32'h0);
    rd_reg(7'd6, v); chk("R10 write pointer write ignored", {8'd0, v}, {8'd0, wp0});

    // Long capture run to force a wrap
    wr_reg(7'd8, 32'h1);
    repeat (300) @(negedge clk);
    wr_reg(7'd8, 32'h0);
    rd_reg(7'd3, v); chk("R6 wrap flag sticky, capture off", {8'd0, v}, 40'd2);
    rd_reg(7'd6, wp0); chk("R8 write pointer after wrap", {8'd0, wp0}, {8'd0, 32'(m_wp)});

    // Oldest-first readout
    wr_reg(7'd5, wp0);
    for (int i = 0; i < 4; i++) begin
      rd_reg(7'd4, v);
      chk("R5 RAM data oldest first", {8'd0, v}, {8'd0, m_mem[(wp0 + i) % D]});
    end
    rd_reg(7'd5, v); chk("R5 read pointer advanced by 4", {8'd0, v}, {8'd0, (wp0 + 4) % D});

    // Two data requests back to back consume two entries
    scan(32'd0, 7'd4, 1'b0, g);
    scan(32'd0, 7'd4, 1'b0, g);
    chk("R5 first of double read", {8'd0, g[31:0]}, {8'd0, m_mem[(wp0 + 4) % D]});
    scan(32'd0, 7'd0, 1'b0, g);
    chk("R5 second of double read skips", {8'd0, g[31:0]}, {8'd0, m_mem[(wp0 + 5) % D]});
    rd_reg(7'd5, v); chk("R5 read pointer after double read", {8'd0, v}, {8'd0, (wp0 + 6) % D});

    // Read pointer fold and wrap
    wr_reg(7'd5, 32'd300);
    rd_reg(7'd5, v); chk("R7 read pointer folded", {8'd0, v}, 40'd44);
    wr_reg(7'd5, 32'd255);
    rd_reg(7'd4, v); chk("R5 last entry", {8'd0, v}, {8'd0, m_mem[255]});
    rd_reg(7'd5, v); chk("R7 R5 read pointer wraps to 0", {8'd0, v}, 40'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule